// File: doc/BRIEF.md
# Codec Serial Frame Link

This block connects a system-side audio datapath to an external audio codec over a full-duplex serial link. The codec supplies a bit clock of 12.288 MHz. The block divides that clock into 256-bit frames, which gives a 48 kHz frame rate. Each frame starts with a 16-bit tag slot, and twelve 20-bit slots follow it. On every frame the block drives a sync marker and serializes a command address, command data and a left/right pair of 18-bit PCM samples. During the same frame it deserializes the codec's outgoing frame and extracts the left and right input samples.

The bit clock and the system clock are unrelated. Receive samples are captured in the bit-clock domain at the end of each frame. A toggle carries that event across two back-to-back flops into the system domain, where it becomes a one-cycle `ready` strobe. The received samples are re-registered in the same cycle as the strobe. System logic reacts to `ready` by reading the new input samples and presenting the transmit values for the next frame. Transmit inputs are taken once, at the rising bit-clock edge that begins a frame.

Top module: `codec_frame_link`

## Requirements
- R1: A frame is exactly 256 bit-clock periods long, so rising edges of `frame_sync` are 256 bit clocks apart.
- R2: `frame_sync` is high for bit positions 0 to 15 of a frame (the tag slot) and low for positions 16 to 255.
- R3: `sdata_out` changes on the rising edge of `bit_clk`. Every slot is sent most significant bit first. Slot 0 occupies positions 0 to 15, and slot n (n from 1 to 12) starts at position 16+20*(n-1).
- R4: The tag slot is sent as 16'hF800: bit 15 marks the frame valid, bits 14 to 11 mark slots 1 to 4 valid, and the other bits are zero.
- R5: Slot 1 carries `cmd_addr` in slot bits 19:12, with bits 11:0 zero.
- R6: Slot 2 carries `cmd_data` in slot bits 19:4, with bits 3:0 zero.
- R7: Slot 3 carries `tx_left` and slot 4 carries `tx_right`, each placed in slot bits 19:2, with bits 1:0 zero.
- R8: Slots 5 to 12 (positions 96 to 255) are sent as zero.
- R9: The transmit inputs are captured at the rising edge that starts position 0. A change to them during a frame does not alter that frame.
- R10: `sdata_in` is sampled on the falling edge of `bit_clk`. After a frame completes, `rx_left` equals bits 19:2 of received slot 3 and `rx_right` equals bits 19:2 of received slot 4.
- R11: `ready` is a single `sys_clk` cycle pulse, issued exactly once for each completed received frame.
- R12: `rx_left` and `rx_right` change only on the edge where `ready` rises. They hold their value in every other cycle.
- R13: While `rst_n` is low, `frame_sync`, `sdata_out`, `ready`, `rx_left` and `rx_right` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bit_clk | input | 1 | Serial bit clock from the codec |
| frame_sync | output | 1 | Frame marker, high during the tag slot |
| sdata_out | output | 1 | Serial data to the codec |
| sdata_in | input | 1 | Serial data from the codec |
| cmd_addr | input | 8 | Command address sent in slot 1 |
| cmd_data | input | 16 | Command data sent in slot 2 |
| tx_left | input | 18 | Left PCM sample to send |
| tx_right | input | 18 | Right PCM sample to send |
| rx_left | output | 18 | Left PCM sample received |
| rx_right | output | 18 | Right PCM sample received |
| ready | output | 1 | One-cycle strobe in the system domain when new samples are available |

## Verification
The bench builds the block with its default parameters: 18-bit samples, 20-bit slots, a 16-bit tag and twelve slots, which makes a 256-bit frame. At these widths the sign-bit and full-scale corners (0x1FFFF, 0x20000, all ones) can be reached in both directions. The codec model can fill the unused slots and the two low slot bits with ones, so any misplaced bit shows up. With an 81 ns bit clock against the 4 ns system clock, each frame spans about 5,200 system cycles. This lets a dozen frames check the crossing, the per-frame strobe count and the hold of the receive outputs between strobes.

// File: rtl/codec_frame_link.sv
module codec_frame_link #(
  parameter int SMP_W  = 18,
  parameter int SLOT_W = 20,
  parameter int TAG_W  = 16,
  parameter int NSLOT  = 12,
  parameter int ADR_W  = 8,
  parameter int DAT_W  = 16
) (
  input  logic             sys_clk,
  input  logic             rst_n,
  input  logic             bit_clk,
  output logic             frame_sync,
  output logic             sdata_out,
  input  logic             sdata_in,
  input  logic [ADR_W-1:0] cmd_addr,
  input  logic [DAT_W-1:0] cmd_data,
  input  logic [SMP_W-1:0] tx_left,
  input  logic [SMP_W-1:0] tx_right,
  output logic [SMP_W-1:0] rx_left,
  output logic [SMP_W-1:0] rx_right,
  output logic             ready
);
  localparam int FRAME_W = TAG_W + NSLOT * SLOT_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int TAIL_W  = FRAME_W - TAG_W - 4 * SLOT_W;
  localparam int L_MSB   = FRAME_W - 1 - TAG_W - 2 * SLOT_W;
  localparam int R_MSB   = L_MSB - SLOT_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [TAG_W-1:0] TAG  = {5'b11111, {(TAG_W-5){1'b0}}};

  logic [CNT_W-1:0]   pos, pos_nx;
  logic [FRAME_W-2:0] tx_sr, rx_sr;
  logic [FRAME_W-1:0] tx_frame, rx_frame;
  logic [SMP_W-1:0]   rxl_b, rxr_b;
  logic               armed, tgl;
  logic [2:0]         tsync;

  assign pos_nx   = (pos == LAST) ? '0 : pos + CNT_W'(1);
  assign tx_frame = {TAG,
                     cmd_addr, {(SLOT_W-ADR_W){1'b0}},
                     cmd_data, {(SLOT_W-DAT_W){1'b0}},
                     tx_left,  {(SLOT_W-SMP_W){1'b0}},
                     tx_right, {(SLOT_W-SMP_W){1'b0}},
                     {TAIL_W{1'b0}}};
  assign rx_frame = {rx_sr, sdata_in};

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n) begin
      pos        <= LAST;
      tx_sr      <= '0;
      frame_sync <= 1'b0;
      sdata_out  <= 1'b0;
      armed      <= 1'b0;
    end else begin
      pos        <= pos_nx;
      armed      <= 1'b1;
      frame_sync <= pos_nx < CNT_W'(TAG_W);
      if (pos_nx == '0) begin
        sdata_out <= tx_frame[FRAME_W-1];
        tx_sr     <= tx_frame[FRAME_W-2:0];
      end else begin
        sdata_out <= tx_sr[FRAME_W-2];
        tx_sr     <= {tx_sr[FRAME_W-3:0], 1'b0};
      end
    end

  always_ff @(negedge bit_clk or negedge rst_n)
    if (!rst_n) begin
      rx_sr <= '0;
      rxl_b <= '0;
      rxr_b <= '0;
      tgl   <= 1'b0;
    end else begin
      rx_sr <= rx_frame[FRAME_W-2:0];
      if (armed && pos == LAST) begin
        rxl_b <= rx_frame[L_MSB -: SMP_W];
        rxr_b <= rx_frame[R_MSB -: SMP_W];
        tgl   <= ~tgl;
      end
    end

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      tsync    <= '0;
      ready    <= 1'b0;
      rx_left  <= '0;
      rx_right <= '0;
    end else begin
      tsync <= {tsync[1:0], tgl};
      ready <= tsync[1] ^ tsync[2];
      if (tsync[1] ^ tsync[2]) begin
        rx_left  <= rxl_b;
        rx_right <= rxr_b;
      end
    end
endmodule

// File: rtl/codec_frame_link_chk.sv
module codec_frame_link_chk #(
  parameter int SMP_W   = 18,
  parameter int FRAME_W = 256,
  parameter int TAG_W   = 16,
  parameter int SLOT_W  = 20
) (
  input logic             sys_clk,
  input logic             rst_n,
  input logic             bit_clk,
  input logic             frame_sync,
  input logic             sdata_out,
  input logic             ready,
  input logic [SMP_W-1:0] rx_left,
  input logic [SMP_W-1:0] rx_right
);
  localparam int CW = $clog2(FRAME_W);
  localparam logic [CW-1:0] TAIL0 = CW'(TAG_W + 4 * SLOT_W);
  logic [CW-1:0] ccnt;

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n) ccnt <= CW'(FRAME_W - 1);
    else        ccnt <= (ccnt == CW'(FRAME_W - 1)) ? '0 : ccnt + CW'(1);

  p_sync_window_r2: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_sync == (ccnt < CW'(TAG_W)));

  p_tag_bits_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (ccnt < CW'(TAG_W)) |-> (sdata_out == (ccnt < CW'(5))));

  p_tail_zero_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (ccnt >= TAIL0) |-> !sdata_out);

  p_ready_pulse_r11: assert property (@(posedge sys_clk) disable iff (!rst_n)
    ready |=> !ready);

  p_rx_hold_r12: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !ready |-> ($stable(rx_left) && $stable(rx_right)));
endmodule

bind codec_frame_link codec_frame_link_chk u_chk (
  .sys_clk(sys_clk), .rst_n(rst_n), .bit_clk(bit_clk),
  .frame_sync(frame_sync), .sdata_out(sdata_out), .ready(ready),
  .rx_left(rx_left), .rx_right(rx_right)
);

// File: tb/codec_frame_link_tb_top.sv
module codec_frame_link_tb_top;
  localparam int NFR = 12;

  logic sys_clk = 0, bit_clk = 0, rst_n = 0, sdata_in = 0;
  logic frame_sync, sdata_out, ready;
  logic [7:0]  cmd_addr = 8'h26;
  logic [15:0] cmd_data = 16'h1234;
  logic [17:0] tx_left = 18'h15555, tx_right = 18'h2AAAA;
  logic [17:0] rx_left, rx_right;

  codec_frame_link dut_i (
    .sys_clk(sys_clk), .rst_n(rst_n), .bit_clk(bit_clk),
    .frame_sync(frame_sync), .sdata_out(sdata_out), .sdata_in(sdata_in),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .tx_left(tx_left), .tx_right(tx_right),
    .rx_left(rx_left), .rx_right(rx_right), .ready(ready)
  );

  always #2 sys_clk = ~sys_clk;
  initial forever begin #40 bit_clk = 1; #41 bit_clk = 0; end

  int n_cmp = 0, n_bad = 0, frames_done = 0, readies = 0;
  bit done_flag = 0;

  task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [255:0] build_tx(logic [7:0] a, logic [15:0] d, logic [17:0] l, logic [17:0] r);
    return {16'hF800, a, 12'h000, d, 4'h0, l, 2'b00, r, 2'b00, 160'b0};
  endfunction

  function automatic logic [255:0] rand_frame();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  logic [255:0] cf = '0, exp_tx = '0, cap_tx = '0, cap_sync = '0;
  logic [17:0]  cur_l = 0, cur_r = 0, done_l = 0, done_r = 0;
  int bpos = 0, fidx = 0;
  bit started = 0, sync_prev = 0, midchg = 0;

  // codec model and transmit checker, bit-clock side
  initial begin
    void'($urandom(32'd20071));
    wait (rst_n);
    forever begin
      @(posedge bit_clk); #1;
      if (frame_sync && !sync_prev) begin
        if (started) chk(bpos == 255, "R1 frame length", 256'(bpos + 1), 256'd256);
        bpos = 0; started = 1;
      end else if (started) bpos++;
      sync_prev = frame_sync;
      if (!started) continue;
      if (bpos == 0) begin
        exp_tx = build_tx(cmd_addr, cmd_data, tx_left, tx_right);
        midchg = 0;
        case (fidx)
          0: cf = '1;
          1: cf = '0;
          2: cf = {128{2'b10}};
          default: cf = rand_frame();
        endcase
        cur_l = cf[199 -: 18];
        cur_r = cf[179 -: 18];
      end
      sdata_in = cf[255 - bpos];
      if (bpos == 10 && fidx % 4 == 3) begin // R9: change before slots 1-4 go out
        cmd_addr = ~cmd_addr; cmd_data = ~cmd_data; tx_left = ~tx_left; tx_right = ~tx_right;
        midchg = 1;
      end
      if (bpos == 40) begin
        case (fidx)
          0: begin cmd_addr = 8'hFF; cmd_data = 16'hFFFF; tx_left = 18'h1FFFF; tx_right = 18'h20000; end
          1: begin cmd_addr = 8'h00; cmd_data = 16'h0000; tx_left = 18'h00000; tx_right = 18'h00000; end
          2: begin cmd_addr = 8'h80; cmd_data = 16'h0001; tx_left = 18'h20000; tx_right = 18'h1FFFF; end
          3: begin cmd_addr = 8'h01; cmd_data = 16'h8000; tx_left = 18'h3FFFF; tx_right = 18'h3FFFF; end
          default: begin
            cmd_addr = 8'($urandom); cmd_data = 16'($urandom);
            tx_left = 18'($urandom); tx_right = 18'($urandom);
          end
        endcase
      end
      @(negedge bit_clk);
      cap_tx[255 - bpos]   = sdata_out;
      cap_sync[255 - bpos] = frame_sync;
      if (bpos == 255) begin
        chk(cap_sync == {16'hFFFF, 240'b0}, "R2 sync window", cap_sync, {16'hFFFF, 240'b0});
        chk(cap_tx[255:240] == exp_tx[255:240], "R4 tag slot", 256'(cap_tx[255:240]), 256'(exp_tx[255:240]));
        chk(cap_tx[239:220] == exp_tx[239:220], "R5 command address slot", 256'(cap_tx[239:220]), 256'(exp_tx[239:220]));
        chk(cap_tx[219:200] == exp_tx[219:200], "R6 command data slot", 256'(cap_tx[219:200]), 256'(exp_tx[219:200]));
        chk(cap_tx[199:160] == exp_tx[199:160], "R7 PCM slots", 256'(cap_tx[199:160]), 256'(exp_tx[199:160]));
        chk(cap_tx[159:0] == 160'b0, "R8 unused slots", 256'(cap_tx[159:0]), 256'd0);
        chk(cap_tx == exp_tx, midchg ? "R9 mid-frame input change ignored" : "R3 full frame order",
            cap_tx, exp_tx);
        done_l = cur_l; done_r = cur_r;
        frames_done++; fidx++;
      end
    end
  end

  // system-side receive checker
  initial begin
    logic [17:0] held_l = 0, held_r = 0;
    bit prev_rdy = 0, moved = 0;
    wait (rst_n);
    forever begin
      @(negedge sys_clk);
      if (ready) begin
        if (prev_rdy) chk(0, "R11 ready wider than one cycle", 256'd2, 256'd1);
        else begin
          readies++;
          chk(readies == frames_done, "R11 one ready per frame", 256'(readies), 256'(frames_done));
          chk(rx_left == done_l, "R10 left input sample", 256'(rx_left), 256'(done_l));
          chk(rx_right == done_r, "R10 right input sample", 256'(rx_right), 256'(done_r));
          chk(!moved, "R12 outputs held between strobes", 256'(moved), 256'd0);
        end
        held_l = rx_left; held_r = rx_right; moved = 0;
      end else if (rx_left != held_l || rx_right != held_r) moved = 1;
      prev_rdy = ready;
    end
  end

  initial begin
    repeat (10) @(negedge sys_clk);
    chk(frame_sync == 0, "R13 reset frame_sync", 256'(frame_sync), 256'd0);
    chk(sdata_out == 0, "R13 reset sdata_out", 256'(sdata_out), 256'd0);
    chk(ready == 0, "R13 reset ready", 256'(ready), 256'd0);
    chk(rx_left == 0 && rx_right == 0, "R13 reset rx samples", 256'({rx_left, rx_right}), 256'd0);
    @(negedge bit_clk); #5 rst_n = 1;
    wait (frames_done >= NFR);
    repeat (50) @(negedge sys_clk);
    chk(readies == frames_done, "R11 final strobe count", 256'(readies), 256'(frames_done));
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge sys_clk);
    chk(0, "watchdog expired", 256'(frames_done), 256'(NFR));
    finish_run();
  end
endmodule